// File: doc/BRIEF.md
# Double-Buffered Percent-Duty PWM Generator

This block produces one single-slope PWM waveform from two settings that a host writes through a byte-wide register port. The host gives the output rate as a 16-bit frequency in hertz and the duty as a whole percentage. A sequential divider converts these into clock-tick counts. It takes the nominal tick rate `CLK_HZ`, divides it by the frequency to get the period, and then computes the high time as the period times the percentage, divided by one hundred.

The frequency is written as two bytes. The low byte waits in a holding register until the high byte arrives, and the two then form the staged frequency in one step. The staged frequency becomes a request only when the duty register is written. The duty write starts the calculation for both values. The results go into a shadow pair, and the running counter takes that pair only when it wraps, so a period is never partly old and partly new. Invalid frequencies are dropped, and the block keeps what was running.

Top module: `pwm_gen`

## Requirements
- R1: After reset the output is low. It stays low, even if a frequency is written, until the first duty write that carries a valid frequency.
- R2: Register addresses are duty = 0x00, frequency low byte = 0x01 and frequency high byte = 0x02. Writes to any other address change nothing.
- R3: A write to 0x01 only fills a holding byte. The staged frequency becomes {high, held low} at the moment 0x02 is written.
- R4: A staged frequency has no effect on the output until the duty register is written afterwards. That duty write applies frequency and duty together.
- R5: The period in ticks is floor(CLK_HZ / frequency).
- R6: Each period starts with floor(period × duty / 100) high ticks, and the output is low for the rest of the period.
- R7: A duty value above 100 is treated as 100. A duty of 100 keeps the output high through every tick, with no low tick at the wrap.
- R8: A duty of 0 keeps the output low for the whole period.
- R9: A frequency of 0, or one above CLK_HZ/100 (a period under 100 ticks), is rejected, and the running period and duty stay unchanged. A period of exactly 100 ticks is accepted.
- R10: New settings take effect only when the counter wraps. Every whole period on the output is made entirely from one committed setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock at nominal rate CLK_HZ |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe, one cycle per byte |
| wrAddr | input | 8 | Register address |
| wrData | input | 8 | Register write data |
| pwmOut | output | 1 | PWM waveform |

## Verification
The hardest case to reach from the ports is a commit that lands while a period with different settings is still running, because only there could a period mix the old length with the new high time. To reach it, the bench first lets one setting run steadily. It then writes a new frequency and duty at once, without waiting, and measures each of the next several whole periods. Every measured period must match the old pair or the new pair exactly. The other cases follow from the same measurements. A write of the low byte alone must leave a later commit on the old frequency. Stray addresses must change nothing. A rejected frequency must leave the running period length in place.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

  localparam logic [7:0] ADDR_DUTY    = 8'h00;
  localparam logic [7:0] ADDR_FREQ_LO = 8'h01;
  localparam logic [7:0] ADDR_FREQ_HI = 8'h02;

  localparam int PCT_FULL = 100;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;     // snapshot staged frequency and duty request
    logic startPer;    // begin CLK_HZ / freq
    logic latchPer;    // store period quotient
    logic startHigh;   // begin period*duty / 100
    logic loadShadow;  // move result into shadow pair, mark pending
  } ctrl_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_DIV_PER,
    ST_HIGH_START,
    ST_DIV_HIGH
  } ctrl_state_t;

endpackage

// File: rtl/pwm_gen_divider.sv
module pwm_gen_divider #(
  parameter int DIV_W = 27,
  parameter int DEN_W = 16,
  parameter int QUO_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIV_W-1:0] dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic             done,
  output logic [QUO_W-1:0] quotient
);

  localparam int CNT_W = $clog2(DIV_W + 1);

  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] den;
  logic [DIV_W-1:0] quo;
  logic [CNT_W-1:0] stepsLeft;
  logic             busy;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             take;

  always_comb begin
    trial = {rem, quo[DIV_W-1]};
    take  = (trial >= {1'b0, den});
    diff  = trial - {1'b0, den};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rem       <= '0;
      den       <= '0;
      quo       <= '0;
      stepsLeft <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem       <= '0;
        den       <= divisor;
        quo       <= dividend;
        stepsLeft <= CNT_W'(DIV_W);
        busy      <= 1'b1;
      end else if (busy) begin
        rem       <= take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        quo       <= {quo[DIV_W-2:0], take};
        stepsLeft <= stepsLeft - CNT_W'(1);
        if (stepsLeft == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo[QUO_W-1:0];

  // R5
  start_accepted_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> busy);

  // R5
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/pwm_gen_ctrl.sv
module pwm_gen_ctrl
  import pwm_gen_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         dutyWrite,
  input  logic         workValid,
  input  logic         divDone,
  output ctrl_strobe_t strobe
);

  ctrl_state_t state;
  ctrl_state_t nextState;
  logic        reqFlag;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (reqFlag) begin
          strobe.capture = 1'b1;
          nextState      = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (workValid) begin
          strobe.startPer = 1'b1;
          nextState       = ST_DIV_PER;
        end else begin
          nextState = ST_IDLE;
        end
      end
      ST_DIV_PER: begin
        if (divDone) begin
          strobe.latchPer = 1'b1;
          nextState       = ST_HIGH_START;
        end
      end
      ST_HIGH_START: begin
        strobe.startHigh = 1'b1;
        nextState        = ST_DIV_HIGH;
      end
      ST_DIV_HIGH: begin
        if (divDone) begin
          strobe.loadShadow = 1'b1;
          nextState         = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      reqFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (dutyWrite)           reqFlag <= 1'b1;
      else if (strobe.capture) reqFlag <= 1'b0;
    end
  end

  // R9
  reject_returns_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && !workValid) |=> (state == ST_IDLE));

endmodule

// File: rtl/pwm_gen_datapath.sv
module pwm_gen_datapath
  import pwm_gen_pkg::*;
#(
  parameter int CLK_HZ = 1_000_000,
  parameter int FREQ_W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [7:0]   wrAddr,
  input  logic [7:0]   wrData,
  input  ctrl_strobe_t strobe,
  output logic         dutyWrite,
  output logic         workValid,
  output logic         divDone,
  output logic         pwmOut
);

  localparam int              PER_W    = $clog2(CLK_HZ + 1);
  localparam longint unsigned PROD_MAX = 64'(CLK_HZ) * 64'(PCT_FULL);
  localparam int              DIV_W    = $clog2(PROD_MAX + 1);
  localparam logic [31:0]     MAX_HZ   = 32'(CLK_HZ / PCT_FULL);
  localparam int              DUTY_W   = $clog2(PCT_FULL + 1);

  // host-facing staging
  logic [7:0]        freqLoHold;
  logic [FREQ_W-1:0] freqStaged;
  logic [DUTY_W-1:0] dutyReq;
  // commit working copies
  logic [FREQ_W-1:0] workFreq;
  logic [DUTY_W-1:0] workDuty;
  logic [PER_W-1:0]  workPer;
  // double buffer
  logic [PER_W-1:0]  shadowPer;
  logic [PER_W-1:0]  shadowHigh;
  logic              pending;
  logic [PER_W-1:0]  actPer;
  logic [PER_W-1:0]  actHigh;
  logic              armed;
  logic [PER_W-1:0]  cnt;
  logic              wrap;
  // divider hookup
  logic              divStart;
  logic [DIV_W-1:0]  divDividend;
  logic [FREQ_W-1:0] divDivisor;
  logic [PER_W-1:0]  divQuotient;

  assign dutyWrite = wrEn && (wrAddr == ADDR_DUTY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freqLoHold <= '0;
      freqStaged <= '0;
      dutyReq    <= '0;
    end else if (wrEn) begin
      unique case (wrAddr)
        ADDR_FREQ_LO: freqLoHold <= wrData;
        ADDR_FREQ_HI: freqStaged <= {wrData, freqLoHold};
        ADDR_DUTY:    dutyReq    <= (wrData > 8'(PCT_FULL)) ? DUTY_W'(PCT_FULL)
                                                            : wrData[DUTY_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workFreq <= '0;
      workDuty <= '0;
      workPer  <= '0;
    end else begin
      if (strobe.capture) begin
        workFreq <= freqStaged;
        workDuty <= dutyReq;
      end
      if (strobe.latchPer) workPer <= divQuotient;
    end
  end

  assign workValid = (workFreq != '0) && (32'(workFreq) <= MAX_HZ);

  always_comb begin
    divStart = strobe.startPer || strobe.startHigh;
    if (strobe.startPer) begin
      divDividend = DIV_W'(CLK_HZ);
      divDivisor  = workFreq;
    end else begin
      divDividend = DIV_W'(workPer) * DIV_W'(workDuty);
      divDivisor  = FREQ_W'(PCT_FULL);
    end
  end

  pwm_gen_divider #(
    .DIV_W (DIV_W),
    .DEN_W (FREQ_W),
    .QUO_W (PER_W)
  ) u_div (
    .clk      (clk),
    .rstN     (rstN),
    .start    (divStart),
    .dividend (divDividend),
    .divisor  (divDivisor),
    .done     (divDone),
    .quotient (divQuotient)
  );

  assign wrap = !armed || (cnt == actPer - PER_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowPer  <= '0;
      shadowHigh <= '0;
      pending    <= 1'b0;
      actPer     <= '0;
      actHigh    <= '0;
      armed      <= 1'b0;
      cnt        <= '0;
    end else begin
      if (strobe.loadShadow) begin
        shadowPer  <= workPer;
        shadowHigh <= divQuotient;
      end
      if (strobe.loadShadow)      pending <= 1'b1;
      else if (wrap && pending)   pending <= 1'b0;

      if (wrap) begin
        cnt <= '0;
        if (pending) begin
          actPer  <= shadowPer;
          actHigh <= shadowHigh;
          armed   <= 1'b1;
        end
      end else begin
        cnt <= cnt + PER_W'(1);
      end
    end
  end

  assign pwmOut = armed && (cnt < actHigh);

  // R10
  commit_at_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(actHigh) || !$stable(actPer)) |-> (cnt == '0));

  // R10
  count_in_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (cnt < actPer));

  // R9
  min_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> (actPer >= PER_W'(PCT_FULL)));

  // R7
  high_within_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    pending |-> (shadowHigh <= shadowPer));

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_gen_pkg::*;
#(
  parameter int CLK_HZ = 1_000_000,
  parameter int FREQ_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrAddr,
  input  logic [7:0] wrData,
  output logic       pwmOut
);

  ctrl_strobe_t strobe;
  logic         dutyWrite;
  logic         workValid;
  logic         divDone;

  pwm_gen_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .dutyWrite (dutyWrite),
    .workValid (workValid),
    .divDone   (divDone),
    .strobe    (strobe)
  );

  pwm_gen_datapath #(
    .CLK_HZ (CLK_HZ),
    .FREQ_W (FREQ_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strobe    (strobe),
    .dutyWrite (dutyWrite),
    .workValid (workValid),
    .divDone   (divDone),
    .pwmOut    (pwmOut)
  );

endmodule

// File: tb/pwm_gen_test.sv
module pwm_gen_test;

  localparam int CLK_HZ  = 1_000_000;
  localparam int TIMEOUT = 5000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       pwmOut;

  int vecCount = 0;
  int errCount = 0;
  int cycles   = 0;
  bit monBusy  = 1'b0;

  typedef enum int {K_PULSE, K_LEVEL, K_EITHER} kind_t;
  typedef struct {
    kind_t kind;
    int    hi, lo, hi2, lo2;
    int    span;
    string tag;
  } item_t;
  item_t sbQ[$];

  pwm_gen #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .pwmOut(pwmOut)
  );

  always #10 clk = ~clk;

  function automatic int perOf(int f);
    return CLK_HZ / f;
  endfunction
  function automatic int hiOf(int f, int d);
    int dd = (d > 100) ? 100 : d;
    return (perOf(f) * dd) / 100;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setFreq(input int f);
    wr(8'h01, f[7:0]);
    wr(8'h02, f[15:8]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectPulse(input int f, input int d, input string tag);
    item_t it;
    it.kind = K_PULSE; it.hi = hiOf(f, d); it.lo = perOf(f) - hiOf(f, d);
    it.hi2 = 0; it.lo2 = 0; it.span = 0; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic expectEither(input int fa, input int da, input int fb, input int db,
                              input string tag);
    item_t it;
    it.kind = K_EITHER;
    it.hi = hiOf(fa, da);  it.lo = perOf(fa) - hiOf(fa, da);
    it.hi2 = hiOf(fb, db); it.lo2 = perOf(fb) - hiOf(fb, db);
    it.span = 0; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic expectLevel(input int v, input int n, input string tag);
    item_t it;
    it.kind = K_LEVEL; it.hi = v; it.lo = 0; it.hi2 = 0; it.lo2 = 0;
    it.span = n; it.tag = tag;
    sbQ.push_back(it);
  endtask

  task automatic drain();
    wait (sbQ.size() == 0 && !monBusy);
  endtask

  // measure one whole period starting at a rising edge
  task automatic measure(output int hi, output int lo, output bit ok);
    int   guard = 0;
    logic prev;
    ok = 1'b1; hi = 0; lo = 0;
    @(negedge clk); prev = pwmOut;
    forever begin
      @(negedge clk);
      if (!prev && pwmOut) break;
      prev = pwmOut;
      guard++;
      if (guard > TIMEOUT) begin ok = 1'b0; return; end
    end
    hi = 1;
    forever begin
      @(negedge clk);
      if (!pwmOut) break;
      hi++;
      if (hi > TIMEOUT) begin ok = 1'b0; return; end
    end
    lo = 1;
    forever begin
      @(negedge clk);
      if (pwmOut) break;
      lo++;
      if (lo > TIMEOUT) begin ok = 1'b0; return; end
    end
  endtask

  // monitor: pops expected items and compares against the waveform
  initial begin
    forever begin
      item_t it;
      int    hi, lo;
      bit    ok;
      wait (sbQ.size() > 0);
      monBusy = 1'b1;
      it = sbQ.pop_front();
      vecCount++;
      if (it.kind == K_LEVEL) begin
        int bad = 0;
        int seen = 0;
        for (int i = 0; i < it.span; i++) begin
          @(negedge clk);
          if (pwmOut !== it.hi[0]) begin bad++; seen = pwmOut; end
        end
        if (bad != 0) begin
          errCount++;
          $display("FAIL %s: level actual %0d on %0d cycles, expected %0d steady",
                   it.tag, seen, bad, it.hi);
        end
      end else begin
        measure(hi, lo, ok);
        if (!ok) begin
          errCount++;
          $display("FAIL %s: no full period seen, actual hi=%0d lo=%0d expected hi=%0d lo=%0d",
                   it.tag, hi, lo, it.hi, it.lo);
        end else if (it.kind == K_PULSE && (hi != it.hi || lo != it.lo)) begin
          errCount++;
          $display("FAIL %s: actual hi=%0d lo=%0d expected hi=%0d lo=%0d",
                   it.tag, hi, lo, it.hi, it.lo);
        end else if (it.kind == K_EITHER &&
                     !((hi == it.hi && lo == it.lo) || (hi == it.hi2 && lo == it.lo2))) begin
          errCount++;
          $display("FAIL %s: actual hi=%0d lo=%0d expected %0d/%0d or %0d/%0d",
                   it.tag, hi, lo, it.hi, it.lo, it.hi2, it.lo2);
        end
      end
      monBusy = 1'b0;
    end
  end

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190_000) begin
        errCount++;
        $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
        $finish;
      end
    end
  end

  // driver
  initial begin
    idle(4);
    rstN = 1'b1;
    // R1: low after reset
    expectLevel(0, 300, "R1 reset");
    drain();
    // R1/R4: frequency alone does not start the output
    setFreq(5000);
    expectLevel(0, 800, "R1 R4 freq without duty");
    drain();
    // R5/R6: 5000 Hz -> 200 ticks, 25% -> 50 high
    wr(8'h00, 8'd25);
    idle(1200);
    expectPulse(5000, 25, "R5 R6 first commit");
    drain();
    // R10: change both while running; each period is old or new
    setFreq(4000);
    wr(8'h00, 8'd60);
    for (int i = 0; i < 6; i++) expectEither(5000, 25, 4000, 60, "R10 no mixed period");
    drain();
    expectPulse(4000, 60, "R10 new setting settled");
    drain();
    // R4: new frequency waits for a duty write
    setFreq(3000);
    idle(1500);
    expectPulse(4000, 60, "R4 staged freq not applied");
    drain();
    // R5: non-integer period truncates (333 ticks, 109 high)
    wr(8'h00, 8'd33);
    idle(1500);
    expectPulse(3000, 33, "R5 R6 truncation");
    drain();
    // R3: low byte alone is held; commit keeps 3000
    wr(8'h01, 8'h10);
    wr(8'h00, 8'd33);
    idle(1500);
    expectPulse(3000, 33, "R3 low byte held");
    drain();
    // R3: high byte joins the held low byte -> 0x0F10 = 3856 Hz
    wr(8'h02, 8'h0F);
    wr(8'h00, 8'd40);
    idle(1500);
    expectPulse(3856, 40, "R3 high byte completes");
    drain();
    // R2: stray addresses change nothing
    wr(8'h03, 8'h01);
    wr(8'h80, 8'h05);
    wr(8'hFF, 8'h10);
    wr(8'h00, 8'd40);
    idle(1500);
    expectPulse(3856, 40, "R2 other addresses ignored");
    drain();
    // R7: duty above 100 clamps to constant high
    wr(8'h00, 8'd150);
    idle(1500);
    expectLevel(1, 700, "R7 duty clamp high");
    drain();
    wr(8'h00, 8'd100);
    idle(1500);
    expectLevel(1, 700, "R7 duty 100 high");
    drain();
    wr(8'h00, 8'd50);
    idle(1500);
    expectPulse(3856, 50, "R6 back from full");
    drain();
    // R8: duty 0 is constant low
    wr(8'h00, 8'd0);
    idle(1500);
    expectLevel(0, 700, "R8 duty zero low");
    drain();
    // R9: exactly 100 ticks is accepted
    setFreq(10000);
    wr(8'h00, 8'd50);
    idle(1500);
    expectPulse(10000, 50, "R9 100-tick boundary");
    drain();
    // R9: 99-tick period rejected
    setFreq(10001);
    wr(8'h00, 8'd20);
    idle(1500);
    expectPulse(10000, 50, "R9 short period rejected");
    drain();
    // R9: zero frequency rejected
    setFreq(0);
    wr(8'h00, 8'd20);
    idle(1500);
    expectPulse(10000, 50, "R9 zero frequency rejected");
    drain();
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule